// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block returns an I2C bus that may have been left hung by a slave into a known state. It does this once, on the first bus request from the local master after reset. While it runs, it owns the open-drain pull-down enables of both lines and holds the master off. It first pulls SCL low with SDA released. It then toggles SCL for at most `MAX_PULSES` high phases, reading SDA at the end of each high phase.

A released SDA ends the clock-out with a fixed exit: SDA is pulled low while SCL is still released, then SCL is pulled low as well. The block then pulses `done_o` with `fail_o` low. If SDA is still held low after the last permitted pulse, the block pulses `done_o` with `fail_o` high. In either case an internal init flag is set and the grant is raised. From then on, the master's own pull-down enables reach the pins. The sequence does not run again until the next reset.

Every SCL and SDA level the sequencer produces lasts exactly `PHASE_CYCLES` clock cycles, so the pulse rate is set by that parameter.

Top module: `i2c_unhang`

## Requirements
- R1: During and right after reset, both pull-down enables are 0 (lines released), and `busy_o`, `gnt_o`, `done_o` and `fail_o` are all 0.
- R2: Recovery starts only when `req_i` is 1 and recovery has not yet completed since reset. Without a request the lines stay released and `busy_o` stays 0.
- R3: The first phase of a recovery pulls SCL low (`scl_oe_o`=1) and releases SDA (`sda_oe_o`=0).
- R4: Every phase driven by the sequencer lasts exactly `PHASE_CYCLES` cycles, and no more than `MAX_PULSES` SCL high phases (`scl_oe_o`=0) occur in one recovery.
- R5: SDA is sampled in the last cycle of each SCL high phase. If it reads 1, the next phase has `sda_oe_o`=1 with SCL released, the phase after that has both enables at 1, and the recovery then completes with `fail_o`=0.
- R6: If SDA reads 0, SCL is pulled low for one phase. After `MAX_PULSES` such low readings, the recovery completes with `fail_o`=1 at the end of that low phase.
- R7: While `busy_o` is 1, `gnt_o` is 0 and the master's enables `m_scl_oe_i`/`m_sda_oe_i` have no effect on the line outputs.
- R8: Once recovery completes, `gnt_o` stays 1 until reset and the line outputs equal the master's enables. Further requests never restart recovery.
- R9: `done_o` is a single-cycle pulse in the cycle after the last sequencer phase. `busy_o` is 0 in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Master asks for the bus |
| m_scl_oe_i | input | 1 | Master SCL pull-down enable (1 = pull low) |
| m_sda_oe_i | input | 1 | Master SDA pull-down enable (1 = pull low) |
| sda_in_i | input | 1 | Synchronised SDA pin level |
| scl_oe_o | output | 1 | SCL pull-down enable to the pad (1 = pull low) |
| sda_oe_o | output | 1 | SDA pull-down enable to the pad (1 = pull low) |
| busy_o | output | 1 | Recovery in progress |
| gnt_o | output | 1 | Bus handed to the master |
| done_o | output | 1 | One-cycle completion pulse |
| fail_o | output | 1 | SDA never released during the last recovery |

## Verification
The checker enforces the following on every cycle:
- the pulse bound;
- the release-SCL-low start;
- the exclusion between busy and grant;
- the stickiness of the grant;
- the one-cycle completion pulse;
- the line levels just before a success or failure completion.

Exact phase lengths, the full order of line levels for a slave that releases after a given number of pulses, the refusal to rerun, and the pass-through of the master's enables after handover are shown only by the bench scenarios. Those scenarios cover release on the first pulse, on a middle pulse and on the last pulse, and a slave that never releases.

// File: rtl/i2c_unhang_pkg.sv
package i2c_unhang_pkg;

  typedef enum logic [2:0] {
    RS_IDLE,
    RS_PARK,
    RS_CLK_HI,
    RS_CLK_LO,
    RS_EXIT_DAT,
    RS_EXIT_CLK
  } rec_state_e;

  typedef struct packed {
    logic scl_low;
    logic sda_low;
  } line_drv_t;

endpackage

// File: rtl/unhang_phase_timer.sv
module unhang_phase_timer #(
  parameter int PHASE_CYCLES = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (PHASE_CYCLES > 1) ? $clog2(PHASE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(PHASE_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign tick_o = run_i && (cnt_q == LAST);
  assign cnt_en = run_i || (cnt_q != '0);

  always_comb begin
    if (!run_i || tick_o) cnt_d = '0;
    else                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/unhang_sequencer.sv
module unhang_sequencer
  import i2c_unhang_pkg::*;
#(
  parameter int MAX_PULSES = 9
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_i,
  input  logic      tick_i,
  input  logic      sda_i,
  output line_drv_t drv_o,
  output logic      busy_o,
  output logic      init_o,
  output logic      done_o,
  output logic      fail_o
);
  localparam int PCW = $clog2(MAX_PULSES + 1);
  localparam logic [PCW-1:0] PLAST = PCW'(MAX_PULSES);

  rec_state_e     st_q, st_d;
  logic [PCW-1:0] pcnt_q, pcnt_d;
  logic           init_q, init_d;
  logic           fail_q, fail_d;
  logic           done_q, done_d;

  always_comb begin
    st_d   = st_q;
    pcnt_d = pcnt_q;
    init_d = init_q;
    fail_d = fail_q;
    done_d = 1'b0;
    case (st_q)
      RS_IDLE: begin
        if (req_i && !init_q) begin
          st_d   = RS_PARK;
          pcnt_d = '0;
        end
      end
      RS_PARK: if (tick_i) st_d = RS_CLK_HI;
      RS_CLK_HI: begin
        if (tick_i) begin
          if (sda_i) begin
            st_d = RS_EXIT_DAT;
          end else begin
            st_d   = RS_CLK_LO;
            pcnt_d = pcnt_q + 1'b1;
          end
        end
      end
      RS_CLK_LO: begin
        if (tick_i) begin
          if (pcnt_q == PLAST) begin
            st_d   = RS_IDLE;
            init_d = 1'b1;
            fail_d = 1'b1;
            done_d = 1'b1;
          end else begin
            st_d = RS_CLK_HI;
          end
        end
      end
      RS_EXIT_DAT: if (tick_i) st_d = RS_EXIT_CLK;
      RS_EXIT_CLK: begin
        if (tick_i) begin
          st_d   = RS_IDLE;
          init_d = 1'b1;
          fail_d = 1'b0;
          done_d = 1'b1;
        end
      end
      default: st_d = RS_IDLE;
    endcase
  end

  always_comb begin
    drv_o = '{scl_low: 1'b0, sda_low: 1'b0};
    case (st_q)
      RS_PARK:     drv_o = '{scl_low: 1'b1, sda_low: 1'b0};
      RS_CLK_LO:   drv_o = '{scl_low: 1'b1, sda_low: 1'b0};
      RS_EXIT_DAT: drv_o = '{scl_low: 1'b0, sda_low: 1'b1};
      RS_EXIT_CLK: drv_o = '{scl_low: 1'b1, sda_low: 1'b1};
      default:     drv_o = '{scl_low: 1'b0, sda_low: 1'b0};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RS_IDLE;
      pcnt_q <= '0;
      init_q <= 1'b0;
      fail_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pcnt_q <= pcnt_d;
      init_q <= init_d;
      fail_q <= fail_d;
      done_q <= done_d;
    end
  end

  assign busy_o = (st_q != RS_IDLE);
  assign init_o = init_q;
  assign done_o = done_q;
  assign fail_o = fail_q;
endmodule

// File: rtl/unhang_line_mux.sv
module unhang_line_mux
  import i2c_unhang_pkg::*;
(
  input  logic      rec_active_i,
  input  logic      master_en_i,
  input  line_drv_t rec_drv_i,
  input  logic      m_scl_i,
  input  logic      m_sda_i,
  output logic      scl_oe_o,
  output logic      sda_oe_o
);
  always_comb begin
    if (rec_active_i) begin
      scl_oe_o = rec_drv_i.scl_low;
      sda_oe_o = rec_drv_i.sda_low;
    end else if (master_en_i) begin
      scl_oe_o = m_scl_i;
      sda_oe_o = m_sda_i;
    end else begin
      scl_oe_o = 1'b0;
      sda_oe_o = 1'b0;
    end
  end
endmodule

// File: rtl/i2c_unhang.sv
module i2c_unhang
  import i2c_unhang_pkg::*;
#(
  parameter int PHASE_CYCLES = 250,
  parameter int MAX_PULSES   = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic m_scl_oe_i,
  input  logic m_sda_oe_i,
  input  logic sda_in_i,
  output logic scl_oe_o,
  output logic sda_oe_o,
  output logic busy_o,
  output logic gnt_o,
  output logic done_o,
  output logic fail_o
);
  line_drv_t rec_drv;
  logic      tick;
  logic      busy;
  logic      init;

  unhang_phase_timer #(.PHASE_CYCLES(PHASE_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (busy),
    .tick_o (tick)
  );

  unhang_sequencer #(.MAX_PULSES(MAX_PULSES)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (req_i),
    .tick_i (tick),
    .sda_i  (sda_in_i),
    .drv_o  (rec_drv),
    .busy_o (busy),
    .init_o (init),
    .done_o (done_o),
    .fail_o (fail_o)
  );

  unhang_line_mux u_mux (
    .rec_active_i (busy),
    .master_en_i  (init),
    .rec_drv_i    (rec_drv),
    .m_scl_i      (m_scl_oe_i),
    .m_sda_i      (m_sda_oe_i),
    .scl_oe_o     (scl_oe_o),
    .sda_oe_o     (sda_oe_o)
  );

  assign busy_o = busy;
  assign gnt_o  = init;
endmodule

// File: rtl/i2c_unhang_chk.sv
module i2c_unhang_chk #(
  parameter int MAX_PULSES = 9
) (
  input logic clk,
  input logic rst_n,
  input logic scl_oe_o,
  input logic sda_oe_o,
  input logic busy_o,
  input logic gnt_o,
  input logic done_o,
  input logic fail_o
);
  localparam int PW = $clog2(MAX_PULSES + 2) + 1;

  logic          scl_prev_q;
  logic [PW-1:0] pulses_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev_q <= 1'b0;
      pulses_q   <= '0;
    end else begin
      scl_prev_q <= scl_oe_o;
      if (!busy_o)                      pulses_q <= '0;
      else if (scl_prev_q && !scl_oe_o) pulses_q <= pulses_q + 1'b1;
    end
  end

  assert_pulse_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pulses_q <= PW'(MAX_PULSES));

  assert_start_lines_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (scl_oe_o && !sda_oe_o));

  assert_no_grant_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !gnt_o);

  assert_grant_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_o |=> gnt_o);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  assert_exit_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !fail_o) |-> $past(scl_oe_o && sda_oe_o));

  assert_fail_lines_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && fail_o) |-> $past(scl_oe_o && !sda_oe_o));
endmodule

bind i2c_unhang i2c_unhang_chk #(.MAX_PULSES(MAX_PULSES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_oe_o (scl_oe_o),
  .sda_oe_o (sda_oe_o),
  .busy_o   (busy_o),
  .gnt_o    (gnt_o),
  .done_o   (done_o),
  .fail_o   (fail_o)
);

// File: tb/i2c_unhang_tb.sv
`timescale 1ns/1ps
module i2c_unhang_tb;
  localparam int DIV = 4;
  localparam int NP  = 9;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic req = 1'b0, m_scl = 1'b0, m_sda = 1'b0;
  logic sda_in, scl_oe, sda_oe, busy, gnt, done, fail;

  int checks = 0, failures = 0;
  int k_cur = 0;
  int hp_cnt = 0;
  logic prev_scl = 1'b0;
  logic busy_seen = 1'b0, gnt_bad = 1'b0;
  logic mon_en = 1'b0;
  logic [1:0] exp_q[$];
  int len_q[$];
  logic [1:0] prev_snap = 2'b00;
  int run_len = 0, prev_len = 0;
  int cyc = 0;

  assign sda_in = !sda_oe && !(hp_cnt <= k_cur);

  i2c_unhang #(.PHASE_CYCLES(DIV), .MAX_PULSES(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req),
    .m_scl_oe_i(m_scl), .m_sda_oe_i(m_sda), .sda_in_i(sda_in),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .busy_o(busy),
    .gnt_o(gnt), .done_o(done), .fail_o(fail)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // slave model: holds SDA low for the first k_cur SCL high phases
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) hp_cnt <= 0;
    else if (prev_scl && !scl_oe) hp_cnt <= hp_cnt + 1;
    prev_scl <= scl_oe;
    if (busy) begin
      busy_seen = 1'b1;
      if (gnt) gnt_bad = 1'b1;
    end
    if (cyc > 100000) begin
      failures++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", cyc, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // monitor: pops expected line levels and phase lengths
  always @(negedge clk) begin
    if (mon_en) begin
      logic [1:0] snap;
      snap = {scl_oe, sda_oe};
      if (snap !== prev_snap) begin
        if (prev_len != 0) chk(run_len == prev_len, "R4 phase length", run_len, prev_len);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3/R5/R6/R7 unexpected line change", int'(snap), -1);
        end else begin
          logic [1:0] e;
          e = exp_q.pop_front();
          prev_len = len_q.pop_front();
          chk(snap == e, "R3/R5/R6/R7 line levels", int'(snap), int'(e));
        end
        run_len = 1;
        prev_snap = snap;
      end else begin
        run_len++;
      end
    end
  end

  task automatic push(input logic [1:0] v, input int len);
    exp_q.push_back(v);
    len_q.push_back(len);
  endtask

  task automatic run_case(input int k, input logic ms, input logic md);
    int n;
    mon_en = 1'b0;
    req = 1'b0; m_scl = ms; m_sda = md; k_cur = k;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk({scl_oe, sda_oe, busy, gnt, done, fail} == 6'b0, "R1 reset state",
        int'({scl_oe, sda_oe, busy, gnt, done, fail}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({busy, scl_oe, sda_oe} == 3'b0, "R2 idle without request",
        int'({busy, scl_oe, sda_oe}), 0);

    exp_q.delete(); len_q.delete();
    push(2'b10, DIV);
    for (int i = 0; i < ((k < NP) ? k : NP); i++) begin
      push(2'b00, DIV);
      push(2'b10, DIV);
    end
    if (k < NP) begin
      push(2'b00, DIV);
      push(2'b01, DIV);
      push(2'b11, DIV);
    end
    push({ms, md}, 0);
    prev_snap = {scl_oe, sda_oe}; prev_len = 0; run_len = 0;
    busy_seen = 1'b0; gnt_bad = 1'b0;
    mon_en = 1'b1;
    req = 1'b1;

    n = 0;
    while (!done && n < 4000) begin
      @(negedge clk);
      n++;
    end
    chk(done == 1'b1, "R9 completion pulse seen", int'(done), 1);
    chk(fail == (k >= NP), "R5/R6 outcome", int'(fail), int'(k >= NP));
    chk(gnt && !busy, "R8 grant after completion", int'({gnt, busy}), 2);
    @(negedge clk);
    chk(done == 1'b0, "R9 single cycle pulse", int'(done), 0);
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R3 all phases observed", exp_q.size(), 0);
    chk(!gnt_bad && busy_seen, "R7 no grant while busy", int'({gnt_bad, busy_seen}), 1);

    mon_en = 1'b0;
    req = 1'b0;
    repeat (2) @(negedge clk);
    busy_seen = 1'b0;
    req = 1'b1;
    repeat (4 * DIV) @(negedge clk);
    chk(!busy_seen && gnt, "R8 no rerun after completion", int'({busy_seen, gnt}), 1);
    m_scl = ~ms; m_sda = ~md;
    @(negedge clk);
    chk({scl_oe, sda_oe} == {~ms, ~md}, "R8 master drives lines",
        int'({scl_oe, sda_oe}), int'({~ms, ~md}));
  endtask

  initial begin
    run_case(0, 1'b0, 1'b0);
    run_case(3, 1'b1, 1'b0);   // master pull-downs active during recovery: R7
    run_case(NP - 1, 1'b0, 1'b0);
    run_case(NP, 1'b0, 1'b0);
    run_case(40, 1'b0, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule